// File: doc/BRIEF.md
# Dual-Mode Multiplexed Register Port

This block is the register-access port of a telecom framer. A host reaches a small register bank over one 8-bit bus that carries first an address and then a data byte. Three control pins change meaning according to a static strap: with the strap low they are a read strobe, a write strobe and an address-latch enable. With the strap high they are a data strobe, a read/write direction line and an address strobe. Chip select gates every access.

All control inputs cross into the fast internal clock through two-flop synchronizers, and the port acts on the synchronized edges. The bus is split into `ad_i`, `ad_o` and an output enable `ad_oe_o`, and the pad ring builds the tri-state driver from them. The enable is raised only while chip select and the read qualifier are both active. Behind the port sit a few read/write bytes and a few read-only status bytes taken from `status_i`. Every other address reads as zero.

Top module: `mpu_port`

## Requirements
- R1: After reset `ad_oe_o` is 0, `ad_o` is 0, the latched address is 0 and every read/write register holds 0.
- R2: With the strap low (`bus_sel_i`=0) and `cs_ni` low, a rising edge of `ctl_b_i` (active-low write strobe) stores `ad_i` at the latched address.
- R3: With the strap low, while `cs_ni` and `ctl_a_i` (active-low read strobe) are both low, `ad_oe_o` is 1 and `ad_o` shows the byte at the latched address within four clocks.
- R4: With the strap high, a rising edge of `ctl_a_i` (active-low data strobe) while `ctl_b_i` is 0 (write direction) and `cs_ni` is low stores `ad_i` at the latched address.
- R5: With the strap high, while `cs_ni` and `ctl_a_i` are low and `ctl_b_i` is 1 (read direction), `ad_oe_o` is 1 and `ad_o` shows the addressed byte within four clocks.
- R6: In both modes a rising edge of `ale_i` captures `ad_i` as the address, and that address is kept until the next rising edge.
- R7: While `cs_ni` is high, strobes neither write a register nor enable the bus.
- R8: `ad_oe_o` is 0 whenever chip select or the read qualifier has been inactive for four clocks. A strobe with the write direction never enables the bus.
- R9: Addresses 8 and 9 return `status_i[7:0]` and `status_i[15:8]`, and writes to them have no effect. Addresses 0 to 3 are the read/write bytes.
- R10: A read of any other address (4 to 7, 10 to 255) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus-type strap: 0 strobe style, 1 data-strobe/direction style |
| cs_ni | input | 1 | Chip select, active low |
| ctl_a_i | input | 1 | Read strobe (strap 0) or data strobe (strap 1), active low |
| ctl_b_i | input | 1 | Write strobe, active low (strap 0), or direction, 1 = read (strap 1) |
| ale_i | input | 1 | Address latch / address strobe, rising edge captures |
| ad_i | input | 8 | Bus value from the pad |
| ad_o | output | 8 | Read data towards the pad |
| ad_oe_o | output | 1 | Pad output enable |
| status_i | input | 16 | Read-only status bytes |

## Verification
A wrong latched address or a lost write shows at the ports only at the next read, as a wrong byte on `ad_o` about four clocks after the read strobe falls. The bench therefore reads back after every write, including the writes that must be ignored. A stuck or late enable shows on `ad_oe_o` at once, and the bench compares it on every clock against the raw pin history, allowing four clocks of synchronizer latency.

// File: rtl/mpu_port_pkg.sv
package mpu_port_pkg;
  typedef enum logic {BUS_STROBE = 1'b0, BUS_DSTROBE = 1'b1} bus_mode_e;

  typedef struct packed {
    logic cs_n;
    logic ctl_a;
    logic ctl_b;
    logic ale;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, ctl_a: 1'b1, ctl_b: 1'b1, ale: 1'b0};
endpackage

// File: rtl/mpu_sync.sv
module mpu_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] pipe_q [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i <= STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i <= STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o      = pipe_q[STAGES-1];
  assign q_prev_o = pipe_q[STAGES];
endmodule

// File: rtl/mpu_decode.sv
module mpu_decode
  import mpu_port_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  bus_mode_e mode_i,
  input  ctl_t      cur_i,
  input  ctl_t      prev_i,
  output logic      rd_qual_o,
  output logic      wr_pulse_o,
  output logic      ale_rise_o
);
  logic sel_held;
  logic a_rise, b_rise;

  assign sel_held   = !cur_i.cs_n && !prev_i.cs_n;
  assign a_rise     = cur_i.ctl_a && !prev_i.ctl_a;
  assign b_rise     = cur_i.ctl_b && !prev_i.ctl_b;
  assign ale_rise_o = cur_i.ale && !prev_i.ale;

  always_comb begin
    if (mode_i == BUS_DSTROBE) begin
      rd_qual_o  = !cur_i.cs_n && !cur_i.ctl_a && cur_i.ctl_b;
      wr_pulse_o = sel_held && a_rise && !cur_i.ctl_b;
    end else begin
      rd_qual_o  = !cur_i.cs_n && !cur_i.ctl_a;
      wr_pulse_o = sel_held && b_rise;
    end
  end

  // a data-strobe write fires after the strobe is released, so it never meets a read
  assert_excl_rw_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == BUS_DSTROBE) |-> $onehot0({rd_qual_o, wr_pulse_o}));
endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int RW_N = 4,
  parameter int ST_N = 2,
  parameter int ST_BASE = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [ST_N*DW-1:0] status_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] rw_q [RW_N];

  for (genvar g = 0; g < RW_N; g++) begin : g_rw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              rw_q[g] <= '0;
      else if (wr_en_i && addr_i == AW'(g))     rw_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < RW_N; i++)
      if (addr_i == AW'(i)) rdata_o = rw_q[i];
    for (int i = 0; i < ST_N; i++)
      if (addr_i == AW'(ST_BASE + i)) rdata_o = status_i[i*DW +: DW];
  end

  for (genvar g = 0; g < RW_N; g++) begin : g_chk
    assert_hold_no_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(rw_q[g]));
  end
endmodule

// File: rtl/mpu_port.sv
module mpu_port
  import mpu_port_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int RW_N = 4,
  parameter int ST_N = 2,
  parameter int ST_BASE = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             cs_ni,
  input  logic             ctl_a_i,
  input  logic             ctl_b_i,
  input  logic             ale_i,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  input  logic [ST_N*DW-1:0] status_i
);
  localparam int OE_LAT = SYNC_STAGES + 1;
  localparam int CW = $bits(ctl_t);

  ctl_t raw, cur, prev;
  logic [CW-1:0] cur_v, prev_v;
  logic rd_qual, wr_pulse, ale_rise;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata;
  logic [DW-1:0] ad_q;
  logic oe_q;

  assign raw = '{cs_n: cs_ni, ctl_a: ctl_a_i, ctl_b: ctl_b_i, ale: ale_i};

  mpu_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(cur_v), .q_prev_o(prev_v)
  );
  assign cur  = ctl_t'(cur_v);
  assign prev = ctl_t'(prev_v);

  mpu_decode u_dec (
    .clk_i, .rst_ni,
    .mode_i    (bus_mode_e'(bus_sel_i)),
    .cur_i     (cur),
    .prev_i    (prev),
    .rd_qual_o (rd_qual),
    .wr_pulse_o(wr_pulse),
    .ale_rise_o(ale_rise)
  );

  // the address is sampled straight from the pad: the host holds it across the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (ale_rise) addr_q <= AW'(ad_i);
  end

  mpu_regbank #(.AW(AW), .DW(DW), .RW_N(RW_N), .ST_N(ST_N), .ST_BASE(ST_BASE)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i (wr_pulse),
    .addr_i  (addr_q),
    .wdata_i (ad_i),
    .status_i(status_i),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= 1'b0;
      ad_q <= '0;
    end else begin
      oe_q <= rd_qual;
      ad_q <= rdata;
    end
  end

  assign ad_o    = ad_q;
  assign ad_oe_o = oe_q;

  assert_oe_needs_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !$past(cs_ni, OE_LAT));
  assert_addr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_rise |=> $stable(addr_q));
  assert_oe_off_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur.cs_n && prev.cs_n) |=> !ad_oe_o);
endmodule

// File: tb/mpu_port_tb_top.sv
module mpu_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst_ni = 0;
  logic bus_sel = 0, cs_n = 1, ca = 1, cb = 1, ale = 0;
  logic [7:0] ad_in = 0;
  logic [7:0] ad_out;
  logic oe;
  logic [15:0] status = 16'hA55A;

  int n_tests = 0, n_fail = 0;
  logic [7:0] model [int];
  int rd_act_cnt = 0, rd_idle_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(bus_sel), .cs_ni(cs_n),
    .ctl_a_i(ca), .ctl_b_i(cb), .ale_i(ale), .ad_i(ad_in),
    .ad_o(ad_out), .ad_oe_o(oe), .status_i(status)
  );

  function automatic logic [7:0] exp_at(int a);
    if (a < 4)  return model.exists(a) ? model[a] : 8'h00;
    if (a == 8) return status[7:0];
    if (a == 9) return status[15:8];
    return 8'h00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // reference for the enable, compared every clock
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_ni && !done) begin
      logic rd_raw;
      rd_raw = !cs_n && !ca && (bus_sel ? cb : 1'b1);
      if (rd_raw) begin rd_act_cnt++; rd_idle_cnt = 0; end
      else        begin rd_idle_cnt++; rd_act_cnt = 0; end
      if (rd_idle_cnt >= 4 && oe) check("R8 oe while idle", oe, 0);
      if (rd_act_cnt >= 4 && !oe) check("R3/R5 oe while reading", oe, 1);
    end
  end

  task automatic latch(logic [7:0] a);
    ad_in = a; ale = 1; wait_n(6);
    ale = 0; wait_n(2);
  endtask

  task automatic do_write(logic [7:0] d, bit sel);
    ad_in = d; cs_n = !sel; wait_n(2);
    if (bus_sel) begin cb = 0; wait_n(1); ca = 0; wait_n(6); ca = 1; wait_n(6); cb = 1; end
    else begin cb = 0; wait_n(6); cb = 1; wait_n(6); end
    cs_n = 1; wait_n(4);
  endtask

  task automatic do_read(string req, logic [7:0] exp);
    cs_n = 0; wait_n(1);
    ca = 0; wait_n(6);
    check({req, " oe"}, oe, 1);
    check({req, " data"}, ad_out, exp);
    ca = 1; wait_n(1); cs_n = 1; wait_n(5);
  endtask

  initial begin
    wait_n(3);
    check("R1 oe after reset", oe, 0);
    check("R1 data after reset", ad_out, 0);
    rst_ni = 1; wait_n(3);
    do_read("R1 reg0 cleared", 8'h00);
    latch(8'd3);
    do_read("R1 reg3 cleared", 8'h00);

    // strobe-style writes and reads
    for (int i = 0; i < 4; i++) begin
      latch(8'(i)); do_write(8'h11 * 8'(i + 1) ^ 8'h80, 1); model[i] = 8'h11 * 8'(i + 1) ^ 8'h80;
    end
    for (int i = 3; i >= 0; i--) begin
      latch(8'(i)); do_read("R2/R3/R6 strobe rd", exp_at(i));
    end

    // data-strobe style
    bus_sel = 1; wait_n(4);
    latch(8'd2); do_write(8'hC3, 1); model[2] = 8'hC3;
    latch(8'd0); do_write(8'h3C, 1); model[0] = 8'h3C;
    latch(8'd2); do_read("R4/R5 dstrobe rd reg2", exp_at(2));
    latch(8'd0); do_read("R4/R5 dstrobe rd reg0", exp_at(0));
    do_read("R6 address kept", exp_at(0));

    // write direction with strobe low never drives (monitor above)
    latch(8'd1); cs_n = 0; cb = 0; wait_n(1); ca = 0; wait_n(6);
    check("R8 no oe on write dir", oe, 0);
    ca = 1; wait_n(6); cb = 1; cs_n = 1; wait_n(4); model[1] = 8'd1;
    do_read("R4 write during dir check", exp_at(1));

    // chip select high ignored
    latch(8'd1); do_write(8'hEE, 0);
    do_read("R7 dstrobe cs high no write", exp_at(1));
    ca = 0; wait_n(6); check("R7 no oe cs high", oe, 0); ca = 1; wait_n(4);
    bus_sel = 0; wait_n(4);
    latch(8'd3); do_write(8'hEE, 0);
    do_read("R7 strobe cs high no write", exp_at(3));
    ca = 0; wait_n(6); check("R7 no oe cs high strobe", oe, 0); ca = 1; wait_n(4);

    // status bytes
    latch(8'd8); do_write(8'h00, 1);
    do_read("R9 status lo", 8'h5A);
    latch(8'd9); do_write(8'hFF, 1);
    do_read("R9 status hi", 8'hA5);
    status = 16'h1234; wait_n(2);
    do_read("R9 status follows input", 8'h12);

    // unmapped
    latch(8'd5); do_write(8'h77, 1); do_read("R10 addr 5", 8'h00);
    latch(8'd7); do_read("R10 addr 7", 8'h00);
    latch(8'd10); do_read("R10 addr 10", 8'h00);
    latch(8'd255); do_read("R10 addr 255", 8'h00);
    latch(8'd0); do_read("R10 reg0 untouched", exp_at(0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule